// File: doc/BRIEF.md
# Serial Port Sample Clock Generator

This block derives a divided bit clock for a multichannel serial port and steers it onto the receive and transmit clock paths. The source clock can be the internal peripheral clock or either of two external clock pins. A pin source can be taken with either polarity. The generator counts rising edges of the chosen source, which are called ticks below. From these ticks it builds a generated clock with a programmable period. It also emits a one-cycle frame strobe that is aligned with each rising edge of the generated clock.

Everything runs on the peripheral clock. An external pin is brought in through a two-stage synchronizer, and each active edge of the synchronized level becomes one tick. When the internal clock is the source, every peripheral clock cycle is a tick. Configuration arrives as static field inputs. Clock-mode, loopback and clock-stop bits decide whether each serial clock pin is driven by the generator, by the other direction's clock, or left as an input.

Top module: `sclk_gen`

## Requirements
- R1: With select {src_pin_i, src_int_i} = 01, every peripheral clock cycle is a tick. For a divide value D, the generated clock then has a period of D+1 cycles and stays high for ceil((D+1)/2) of them.
- R2: A divide value of 0 is treated as 1, giving a period of 2 ticks and a high phase of 1 tick.
- R3: Select 10 takes ticks from the receive clock pin and select 11 from the transmit clock pin. The generated period is D+1 pin periods. The generated clock changes only on a tick.
- R4: With pin_inv_i = 0 a rising pin edge is a tick, and with pin_inv_i = 1 a falling pin edge is a tick. The generated clock rises on the third peripheral clock edge after the pin edge that caused the tick.
- R5: fs_o is high for exactly one cycle, and only in the cycle in which the generated clock first reads high.
- R6: While gen_en_i is 0, and out of reset, the generated clock and fs_o are low. After gen_en_i rises, the first rising edge of the generated clock comes after ceil((D+1)/2) ticks.
- R7: Select code 00 is reserved. It raises src_bad_o and holds the generated clock low.
- R8: When rx_mode_i is 1 and loop_i is 0, the receive clock pin is driven (rx_clk_oe_o = 1) with the generated clock. When rx_mode_i is 0, the pin is not driven and the internal receive clock follows the pin input.
- R9: When rx_mode_i is 1 and loop_i is 1, the receive clock pin carries the internal transmit clock. That clock is the transmit pin input if tx_mode_i is 0 and the generated clock if tx_mode_i is 1.
- R10: When tx_mode_i is 1, the transmit clock pin is driven with the generated clock, for every stop_i code. When tx_mode_i is 0, the internal transmit clock follows the transmit pin input.
- R11: When stop_i is 10 or 11 and tx_mode_i is 1, the internal receive clock equals the internal transmit clock. When stop_i is 00 or 01, the receive path keeps its own source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal peripheral clock; all state runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_rx_clk_i | input | 1 | Receive clock pin input |
| pin_tx_clk_i | input | 1 | Transmit clock pin input |
| src_pin_i | input | 1 | Upper source-select bit |
| src_int_i | input | 1 | Lower source-select bit |
| pin_inv_i | input | 1 | Take pin source on its falling edge |
| div_i | input | DIV_W | Divide value D |
| gen_en_i | input | 1 | Generator enable |
| rx_mode_i | input | 1 | Receive clock pin is an output |
| tx_mode_i | input | 1 | Transmit clock pin is an output |
| loop_i | input | 1 | Loopback: receive pin follows internal transmit clock |
| stop_i | input | 2 | Clock-stop code; upper bit selects SPI master |
| gclk_o | output | 1 | Generated clock |
| fs_o | output | 1 | Frame strobe at generated clock rise |
| src_bad_o | output | 1 | Reserved source code selected |
| rx_clk_o | output | 1 | Receive clock pin output value |
| rx_clk_oe_o | output | 1 | Receive clock pin output enable |
| rx_clk_int_o | output | 1 | Internal receive clock |
| tx_clk_o | output | 1 | Transmit clock pin output value |
| tx_clk_oe_o | output | 1 | Transmit clock pin output enable |
| tx_clk_int_o | output | 1 | Internal transmit clock |

## Verification
The assertions assume that the configuration fields are quasi-static, so a change can cost at most one irregular period before the period law applies again. They also assume that each pin level lasts at least two peripheral clock cycles, so the synchronizer sees every edge. The stimulus changes configuration only between measurements and waits past the longest period before it takes a new measurement. It toggles the pin clocks with half-periods of three and four cycles. Pin levels change just after a rising clock edge, and all sampling happens on the falling edge.

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_rx_clk_i,
  input  logic             pin_tx_clk_i,
  input  logic             src_pin_i,
  input  logic             src_int_i,
  input  logic             pin_inv_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             gen_en_i,
  input  logic             rx_mode_i,
  input  logic             tx_mode_i,
  input  logic             loop_i,
  input  logic [1:0]       stop_i,
  output logic             gclk_o,
  output logic             fs_o,
  output logic             src_bad_o,
  output logic             rx_clk_o,
  output logic             rx_clk_oe_o,
  output logic             rx_clk_int_o,
  output logic             tx_clk_o,
  output logic             tx_clk_oe_o,
  output logic             tx_clk_int_o
);

  localparam int CW = DIV_W + 2;

  logic [1:0]    rx_s, tx_s;
  logic          lvl_q, gclk_q, first_q, fs_q;
  logic [CW-1:0] ph_q;

  // source selection and tick extraction
  logic use_int, run, pin_lvl, tick;
  assign src_bad_o = !src_pin_i && !src_int_i;
  assign use_int   = !src_pin_i && src_int_i;
  assign run       = gen_en_i && !src_bad_o;
  assign pin_lvl   = (src_int_i ? tx_s[1] : rx_s[1]) ^ pin_inv_i;
  assign tick      = run && (use_int || (pin_lvl && !lvl_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s  <= '0;
      tx_s  <= '0;
      lvl_q <= 1'b0;
    end else begin
      rx_s  <= {rx_s[0], pin_rx_clk_i};
      tx_s  <= {tx_s[0], pin_tx_clk_i};
      lvl_q <= pin_lvl;
    end
  end

  // phase lengths
  logic [CW-1:0] d_eff, hi_len, lo_len, target;
  logic          flip;
  assign d_eff  = (div_i == '0) ? CW'(1) : CW'(div_i);
  assign hi_len = (d_eff + CW'(2)) >> 1;
  assign lo_len = d_eff + CW'(1) - hi_len;
  assign target = (gclk_q || first_q) ? hi_len : lo_len;
  assign flip   = tick && (ph_q + CW'(1) >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      gclk_q  <= 1'b0;
      first_q <= 1'b1;
      fs_q    <= 1'b0;
    end else if (!run) begin
      ph_q    <= '0;
      gclk_q  <= 1'b0;
      first_q <= 1'b1;
      fs_q    <= 1'b0;
    end else begin
      fs_q <= flip && !gclk_q;
      if (flip) begin
        ph_q    <= '0;
        gclk_q  <= !gclk_q;
        first_q <= 1'b0;
      end else if (tick) begin
        ph_q <= ph_q + CW'(1);
      end
    end
  end

  assign gclk_o = gclk_q;
  assign fs_o   = fs_q;

  // clock routing
  assign tx_clk_int_o = tx_mode_i ? gclk_q : pin_tx_clk_i;
  assign tx_clk_o     = gclk_q;
  assign tx_clk_oe_o  = tx_mode_i;
  assign rx_clk_o     = loop_i ? tx_clk_int_o : gclk_q;
  assign rx_clk_oe_o  = rx_mode_i;
  assign rx_clk_int_o = (tx_mode_i && stop_i[1]) ? tx_clk_int_o :
                        rx_mode_i ? rx_clk_o : pin_rx_clk_i;

  // assertions
  p_fs_at_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (gclk_q && !$past(gclk_q)));

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> (!gclk_o && !fs_o));

  p_reserved_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_pin_i && !src_int_i) |=> !gclk_o);

  p_tick_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(gclk_q));

  p_loop_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_i && loop_i && !tx_mode_i) |-> (rx_clk_o == pin_tx_clk_i));

  p_spi_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode_i && stop_i[1]) |-> (rx_clk_int_o == gclk_o));

  p_norm_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode_i && !rx_mode_i && stop_i == 2'b01) |-> (rx_clk_int_o == pin_rx_clk_i));

endmodule

// File: tb/sclk_gen_tb.sv
module sclk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_rx = 1'b0, pin_tx = 1'b0;
  logic src_pin = 1'b0, src_int = 1'b1, inv = 1'b0;
  logic [DIV_W-1:0] div = 8'd4;
  logic en = 1'b0, rx_mode = 1'b0, tx_mode = 1'b0, loopb = 1'b0;
  logic [1:0] stop = 2'b00;
  logic gclk, fs, bad, rx_o, rx_oe, rx_int, tx_o, tx_oe, tx_int;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_gen #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_rx_clk_i(pin_rx), .pin_tx_clk_i(pin_tx),
    .src_pin_i(src_pin), .src_int_i(src_int), .pin_inv_i(inv), .div_i(div),
    .gen_en_i(en), .rx_mode_i(rx_mode), .tx_mode_i(tx_mode), .loop_i(loopb),
    .stop_i(stop), .gclk_o(gclk), .fs_o(fs), .src_bad_o(bad),
    .rx_clk_o(rx_o), .rx_clk_oe_o(rx_oe), .rx_clk_int_o(rx_int),
    .tx_clk_o(tx_o), .tx_clk_oe_o(tx_oe), .tx_clk_int_o(tx_int));

  int n_chk = 0, n_fail = 0;
  int rx_half = 3, tx_half = 4;
  int exp_hi[$], exp_lo[$];
  string exp_tag[$];
  bit mon_on = 0;
  int fs_err = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // pin clock sources, changed just after the rising edge
  initial begin
    int rc = 0, tc = 0;
    forever begin
      @(posedge clk); #1;
      if (rx_half > 0) begin rc++; if (rc >= rx_half) begin pin_rx = ~pin_rx; rc = 0; end end
      if (tx_half > 0) begin tc++; if (tc >= tx_half) begin pin_tx = ~pin_tx; tc = 0; end end
    end
  end

  // monitor: measures generated clock periods and pops expectations
  initial begin
    bit prev_g = 0, started = 0;
    int hi_c = 0, lo_c = 0;
    forever begin
      @(negedge clk);
      if (!mon_on) begin
        started = 0;
      end else begin
        if (fs != (gclk && !prev_g)) fs_err++;
        if (gclk && !prev_g) begin
          if (started && exp_hi.size() > 0) begin
            int eh, el; string t;
            eh = exp_hi.pop_front(); el = exp_lo.pop_front(); t = exp_tag.pop_front();
            chk(hi_c == eh && lo_c == el, t, "period hi*1000+lo",
                hi_c * 1000 + lo_c, eh * 1000 + el);
          end
          started = 1; hi_c = 0; lo_c = 0;
        end
        if (gclk) hi_c++; else lo_c++;
      end
      prev_g = gclk;
    end
  end

  task automatic cfg(bit sp, bit si, bit iv, int d);
    @(negedge clk);
    src_pin = sp; src_int = si; inv = iv; div = DIV_W'(d);
  endtask

  task automatic shape(int h, int l, int n, string tag);
    mon_on = 0;
    repeat (600) @(negedge clk);
    fs_err = 0;
    mon_on = 1;
    for (int i = 0; i < n; i++) begin
      exp_hi.push_back(h); exp_lo.push_back(l); exp_tag.push_back(tag);
    end
    for (int i = 0; i < 5000 && exp_hi.size() > 0; i++) @(negedge clk);
    chk(exp_hi.size() == 0, tag, "periods left unmeasured", exp_hi.size(), 0);
    mon_on = 0;
    exp_hi.delete(); exp_lo.delete(); exp_tag.delete();
    chk(fs_err == 0, "R5", "strobe misaligned cycles", fs_err, 0);
  endtask

  task automatic polar(bit use_tx, bit lvl, string tag);
    bit h[5];
    bit prev_g = 0;
    int seen = 0;
    bit done = 0;
    repeat (200) @(negedge clk);
    for (int i = 0; i < 2000 && !done; i++) begin
      @(negedge clk);
      for (int k = 4; k > 0; k--) h[k] = h[k-1];
      h[0] = use_tx ? pin_tx : pin_rx;
      seen++;
      if (seen > 5 && gclk && !prev_g) begin
        chk(h[3] == lvl && h[4] != lvl, tag, "pin level 3/4 samples before rise",
            int'(h[3]) * 10 + int'(h[4]), int'(lvl) * 10 + int'(!lvl));
        done = 1;
      end
      prev_g = gclk;
    end
    if (!done) chk(0, tag, "no generated rise", 0, 1);
  endtask

  task automatic route(int which, string tag);
    int bad_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 80; i++) begin
      bit ok;
      @(negedge clk);
      case (which)
        0: ok = rx_oe && rx_o == gclk;
        1: ok = !rx_oe && rx_int == pin_rx;
        2: ok = rx_oe && rx_o == pin_tx && rx_int == pin_tx;
        3: ok = rx_o == gclk && rx_int == gclk;
        4: ok = tx_oe && tx_o == gclk && tx_int == gclk;
        5: ok = !tx_oe && tx_int == pin_tx;
        6: ok = rx_int == gclk;
        default: ok = rx_int == pin_rx;
      endcase
      if (!ok) bad_n++;
    end
    chk(bad_n == 0, tag, "routing mismatched cycles", bad_n, 0);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    chk(gclk == 0 && fs == 0, "R6", "reset gclk/fs", int'(gclk) * 10 + int'(fs), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(gclk == 0, "R6", "gclk while disabled", int'(gclk), 0);
    // R6: first rise after hi-phase ticks (D=4 -> 3)
    en = 1'b1;
    k = 0;
    for (int i = 1; i <= 20 && k == 0; i++) begin
      @(negedge clk);
      if (gclk) k = i;
    end
    chk(k == 3, "R6", "cycles to first rise", k, 3);

    // R1 internal source
    cfg(0, 1, 0, 4);   shape(3, 2, 3, "R1");
    cfg(0, 1, 0, 5);   shape(3, 3, 3, "R1");
    cfg(0, 1, 0, 2);   shape(2, 1, 3, "R1");
    cfg(0, 1, 0, 255); shape(128, 128, 2, "R1");
    // R2 zero divide
    cfg(0, 1, 0, 0);   shape(1, 1, 4, "R2");
    // R3 pin sources
    cfg(1, 0, 0, 2);   shape(12, 6, 3, "R3");
    cfg(1, 1, 0, 3);   shape(16, 16, 2, "R3");
    // R4 polarity
    cfg(1, 0, 0, 2);   polar(0, 1'b1, "R4");
    cfg(1, 0, 1, 2);   polar(0, 1'b0, "R4");
    shape(12, 6, 2, "R4");
    cfg(1, 1, 1, 1);   polar(1, 1'b0, "R4");

    // R7 reserved code
    cfg(0, 0, 0, 4);
    repeat (3) @(negedge clk);
    chk(bad == 1, "R7", "src_bad_o", int'(bad), 1);
    k = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (gclk) k++; end
    chk(k == 0, "R7", "gclk high samples", k, 0);
    cfg(0, 1, 0, 4);
    @(negedge clk);
    chk(bad == 0, "R7", "src_bad_o cleared", int'(bad), 0);

    // R6 disable again
    en = 1'b0;
    k = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (i > 0 && (gclk || fs)) k++; end
    chk(k == 0, "R6", "gclk/fs active while disabled", k, 0);
    en = 1'b1;

    // routing
    rx_mode = 1; loopb = 0; tx_mode = 0; stop = 2'b00; route(0, "R8");
    rx_mode = 0;                                       route(1, "R8");
    rx_mode = 1; loopb = 1; tx_mode = 0;               route(2, "R9");
    tx_mode = 1;                                       route(3, "R9");
    rx_mode = 0; loopb = 0; tx_mode = 1; stop = 2'b00; route(4, "R10");
    stop = 2'b10;                                      route(4, "R10");
    tx_mode = 0;                                       route(5, "R10");
    tx_mode = 1; stop = 2'b11;                         route(6, "R11");
    stop = 2'b01;                                      route(7, "R11");

    finish_run();
  end
endmodule